// File: doc/BRIEF.md
# Battery Pack Protection Controller

This block is the control core of a protector for a lithium pack of three or four cells in series. It does not measure anything itself. Its inputs are digital flags that comparators and a cell-sampling sequencer outside the block have already qualified:

- any cell above the overvoltage limit;
- every cell below the charge-enable limit;
- any cell below the undervoltage limit;
- the low-side and high-side overcurrent comparators;
- the low-side and high-side charge-detect comparators;
- an external pack-disable request.

From these flags it drives two active-high outputs, `chg_off` and `dsg_off`, which switch off the charge FET and the discharge FET, and a sleep status flag.

Three fault-persistence timers filter the faults: overvoltage, undervoltage and overcurrent. A timer counts only on cycles where the shared `tick` enable is high. Each timer takes its delay from its own input. A fault is latched only if its flag stays true with no gap until the timer expires. Each latched fault has its own release rule:

- Overvoltage is released when all cells are below the charge-enable limit.
- Overcurrent is released when both overcurrent comparators are false.
- Undervoltage puts the pack to sleep. Only a charge-detect wakes it.

While pack-disable is high, both outputs are forced high and the overcurrent timer is held cleared.

Top module: `pack_guard`

## Requirements
- R1: If `ov_any` is true on D_ov+1 consecutive ticks with no cycle low in between (D_ov = `ov_dly`), `chg_off` is high after the clock edge that carries the last of those ticks. After D_ov ticks it is still low.
- R2: A latched overvoltage keeps `chg_off` high after `ov_any` drops. It is released, one edge later, only by `ce_all` being high.
- R3: If `uv_any` is true on D_uv+1 consecutive ticks, `dsg_off` and `asleep` both go high. The undervoltage timer is held cleared while the block is asleep.
- R4: While reset is high and after it, before any other stimulus, the outputs are `asleep`=1, `dsg_off`=1 and `chg_off`=0.
- R5: Leaving sleep requires `cd_lo` or `cd_hi` to be high at a clock edge. No other input wakes the block, including the release of an undervoltage.
- R6: If `oc_lo` or `oc_hi` (either one) stays true for D_oc+1 consecutive ticks, `dsg_off` goes high. It stays high until both are low, and is released at the next edge after that.
- R7: If a fault flag goes low for even one cycle before its timer expires, the count restarts from zero, and a full D+1 ticks are needed again.
- R8: A high `pack_off` drives both `chg_off` and `dsg_off` high after the next edge. Once `pack_off` is low, both outputs follow the latched faults again.
- R9: While `pack_off` is high, the overcurrent timer is held at zero. After release, the full D_oc+1 ticks are required.
- R10: Cycles without `tick` do not advance any timer. A delay of zero makes a fault act on the first tick that sees its flag.
- R11: Each output is the OR of every reason that forces it, so a latched overvoltage keeps `chg_off` high after `pack_off` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Shared time-base enable for the timers |
| ov_any | input | 1 | Some cell above the overvoltage limit |
| ce_all | input | 1 | All cells below the charge-enable limit |
| uv_any | input | 1 | Some cell below the undervoltage limit |
| oc_lo | input | 1 | Low-side overcurrent comparator |
| oc_hi | input | 1 | High-side overcurrent comparator |
| cd_lo | input | 1 | Low-side charge-detect comparator |
| cd_hi | input | 1 | High-side charge-detect comparator |
| pack_off | input | 1 | External pack-disable request |
| ov_dly | input | DLY_W | Overvoltage delay in ticks |
| uv_dly | input | DLY_W | Undervoltage delay in ticks |
| oc_dly | input | DLY_W | Overcurrent delay in ticks |
| chg_off | output | 1 | Charge FET off, registered |
| dsg_off | output | 1 | Discharge FET off, registered |
| asleep | output | 1 | Low-power sleep status |

## Verification
The bench keeps the default `DLY_W` of 16 but drives small delays at run time: 3 for overvoltage, 2 for undervoltage, 1 for overcurrent, and 0 for the zero-delay case. With these values every expiry, and the tick just before it, can be reached within a few dozen cycles. Each timer boundary (D ticks versus D+1 ticks) is checked on both sides. Ticks are spaced two cycles apart, so the cycles between ticks test that only ticks are counted and that a one-cycle drop restarts a timer.

// File: rtl/pack_guard_pkg.sv
package pack_guard_pkg;

    localparam int FLT_OV  = 0;
    localparam int FLT_UV  = 1;
    localparam int FLT_OC  = 2;
    localparam int NUM_FLT = 3;

    typedef struct packed {
        logic ov_hit;
        logic oc_hit;
        logic sleep;
    } guard_flags_t;

    localparam guard_flags_t FLAGS_RESET = '{ov_hit: 1'b0, oc_hit: 1'b0, sleep: 1'b1};

    function automatic logic any_of2(input logic a, input logic b);
        return a | b;
    endfunction

endpackage

// File: rtl/pg_persist_timer.sv
module pg_persist_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cond,
    input  logic             hold,
    input  logic [DLY_W-1:0] delay,
    output logic             fire
);
    logic [DLY_W-1:0] cnt;
    logic             armed;

    assign armed = cond & ~hold;

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            cnt <= '0;
        end else if (tick && (cnt < delay)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign fire = armed & tick & (cnt >= delay);

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (!cond || hold) |=> !fire);

endmodule

// File: rtl/pg_fault_state.sv
module pg_fault_state
    import pack_guard_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_FLT-1:0] fire,
    input  logic               ce_all,
    input  logic               oc_lo,
    input  logic               oc_hi,
    input  logic               cd_lo,
    input  logic               cd_hi,
    input  logic               pack_off,
    output guard_flags_t       flags,
    output logic               chg_off,
    output logic               dsg_off
);
    guard_flags_t nxt;

    always_comb begin
        nxt = flags;
        if (fire[FLT_OV])       nxt.ov_hit = 1'b1;
        else if (ce_all)        nxt.ov_hit = 1'b0;
        if (fire[FLT_OC])       nxt.oc_hit = 1'b1;
        else if (!any_of2(oc_lo, oc_hi)) nxt.oc_hit = 1'b0;
        if (fire[FLT_UV])       nxt.sleep = 1'b1;
        else if (any_of2(cd_lo, cd_hi)) nxt.sleep = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= FLAGS_RESET;
            chg_off <= 1'b0;
            dsg_off <= 1'b1;
        end else begin
            flags   <= nxt;
            chg_off <= pack_off | nxt.ov_hit;
            dsg_off <= pack_off | nxt.oc_hit | nxt.sleep;
        end
    end

    // R2
    ov_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.ov_hit) |-> $past(ce_all));
    // R5
    wake_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.sleep) |-> $past(cd_lo || cd_hi));
    // R6
    oc_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.oc_hit) |-> $past(!oc_lo && !oc_hi));
    // R3
    sleep_dsg_chk: assert property (@(posedge clk) disable iff (rst)
        flags.sleep |-> dsg_off);
    // R8
    disable_out_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(pack_off) && !$past(rst)) |-> (chg_off && dsg_off));

endmodule

// File: rtl/pack_guard.sv
module pack_guard
    import pack_guard_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ov_any,
    input  logic             ce_all,
    input  logic             uv_any,
    input  logic             oc_lo,
    input  logic             oc_hi,
    input  logic             cd_lo,
    input  logic             cd_hi,
    input  logic             pack_off,
    input  logic [DLY_W-1:0] ov_dly,
    input  logic [DLY_W-1:0] uv_dly,
    input  logic [DLY_W-1:0] oc_dly,
    output logic             chg_off,
    output logic             dsg_off,
    output logic             asleep
);
    guard_flags_t       flags;
    logic [NUM_FLT-1:0] cond_v;
    logic [NUM_FLT-1:0] hold_v;
    logic [NUM_FLT-1:0] fire_v;
    logic [DLY_W-1:0]   dly_v [NUM_FLT];

    always_comb begin
        cond_v[FLT_OV] = ov_any;
        cond_v[FLT_UV] = uv_any;
        cond_v[FLT_OC] = any_of2(oc_lo, oc_hi);
        hold_v[FLT_OV] = 1'b0;
        hold_v[FLT_UV] = flags.sleep;
        hold_v[FLT_OC] = pack_off;
        dly_v[FLT_OV]  = ov_dly;
        dly_v[FLT_UV]  = uv_dly;
        dly_v[FLT_OC]  = oc_dly;
    end

    for (genvar g = 0; g < NUM_FLT; g++) begin : g_tmr
        pg_persist_timer #(.DLY_W(DLY_W)) u_tmr (
            .clk  (clk),
            .rst  (rst),
            .tick (tick),
            .cond (cond_v[g]),
            .hold (hold_v[g]),
            .delay(dly_v[g]),
            .fire (fire_v[g])
        );
    end

    pg_fault_state u_state (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire_v),
        .ce_all  (ce_all),
        .oc_lo   (oc_lo),
        .oc_hi   (oc_hi),
        .cd_lo   (cd_lo),
        .cd_hi   (cd_hi),
        .pack_off(pack_off),
        .flags   (flags),
        .chg_off (chg_off),
        .dsg_off (dsg_off)
    );

    assign asleep = flags.sleep;

    // R1
    ov_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.ov_hit) |-> $past(ov_any && tick));
    // R9
    oc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.oc_hit) |-> $past(!pack_off && tick));
    // R3
    uv_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.sleep) |-> $past(uv_any && tick));

endmodule

// File: tb/pack_guard_test.sv
module pack_guard_test;
    localparam int DLY_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, ov_any = 1'b0, ce_all = 1'b0, uv_any = 1'b0;
    logic oc_lo = 1'b0, oc_hi = 1'b0, cd_lo = 1'b0, cd_hi = 1'b0, pack_off = 1'b0;
    logic [DLY_W-1:0] ov_dly = 16'd3, uv_dly = 16'd2, oc_dly = 16'd1;
    logic chg_off, dsg_off, asleep;
    int checks = 0, failures = 0, cycles = 0;

    always #2 clk = ~clk;

    pack_guard #(.DLY_W(DLY_W)) uut (
        .clk(clk), .rst(rst), .tick(tick), .ov_any(ov_any), .ce_all(ce_all),
        .uv_any(uv_any), .oc_lo(oc_lo), .oc_hi(oc_hi), .cd_lo(cd_lo),
        .cd_hi(cd_hi), .pack_off(pack_off), .ov_dly(ov_dly), .uv_dly(uv_dly),
        .oc_dly(oc_dly), .chg_off(chg_off), .dsg_off(dsg_off), .asleep(asleep)
    );

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual chg/dsg/sleep=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(); tick = 1'b0; step();
        end
    endtask

    task automatic outs_is(input string req, input logic c, input logic d, input logic s);
        chk(req, {chg_off, dsg_off, asleep}, {c, d, s});
    endtask

    task automatic t_reset();
        rst = 1'b1; step(3);
        outs_is("R4 in reset", 1'b0, 1'b1, 1'b1);
        rst = 1'b0; step(2);
        outs_is("R4 after reset", 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_wake();
        oc_lo = 1'b1; ce_all = 1'b1; ticks(3);
        outs_is("R5 no wake on other inputs", 1'b0, 1'b1, 1'b1);
        oc_lo = 1'b0; ce_all = 1'b0; step();
        cd_hi = 1'b1; step(); cd_hi = 1'b0; step();
        outs_is("R5 wake on cd_hi", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_ov();
        ov_any = 1'b1; ticks(3);
        outs_is("R1 before expiry", 1'b0, 1'b0, 1'b0);
        ticks(1);
        outs_is("R1 at expiry", 1'b1, 1'b0, 1'b0);
        ov_any = 1'b0; ticks(3);
        outs_is("R2 held without ce", 1'b1, 1'b0, 1'b0);
        ce_all = 1'b1; step(); ce_all = 1'b0; step();
        outs_is("R2 released by ce", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_restart();
        ov_any = 1'b1; ticks(3);
        ov_any = 1'b0; step();
        ov_any = 1'b1; ticks(3);
        outs_is("R7 restart after drop", 1'b0, 1'b0, 1'b0);
        ticks(1);
        outs_is("R7 full count after drop", 1'b1, 1'b0, 1'b0);
        ov_any = 1'b0; ce_all = 1'b1; step(); ce_all = 1'b0; step();
    endtask

    task automatic t_zero();
        ov_dly = '0; ov_any = 1'b1; step(4);
        outs_is("R10 no count without tick", 1'b0, 1'b0, 1'b0);
        ticks(1);
        outs_is("R10 zero delay first tick", 1'b1, 1'b0, 1'b0);
        ov_any = 1'b0; ce_all = 1'b1; step(); ce_all = 1'b0; step();
        ov_dly = 16'd3;
    endtask

    task automatic t_oc();
        oc_hi = 1'b1; ticks(1);
        outs_is("R6 before oc expiry", 1'b0, 1'b0, 1'b0);
        ticks(1);
        outs_is("R6 oc_hi latched", 1'b0, 1'b1, 1'b0);
        oc_hi = 1'b0; oc_lo = 1'b1; step(3);
        outs_is("R6 held while oc_lo", 1'b0, 1'b1, 1'b0);
        oc_lo = 1'b0; step();
        outs_is("R6 released when both low", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_disable();
        pack_off = 1'b1; oc_lo = 1'b1; step();
        outs_is("R8 disable forces both", 1'b1, 1'b1, 1'b0);
        ticks(5);
        pack_off = 1'b0; step();
        outs_is("R9 oc not latched under disable", 1'b0, 1'b0, 1'b0);
        ticks(1);
        outs_is("R9 timer restarts after disable", 1'b0, 1'b0, 1'b0);
        ticks(1);
        outs_is("R9 oc latches after full count", 1'b0, 1'b1, 1'b0);
        oc_lo = 1'b0; step();
    endtask

    task automatic t_combo();
        ov_any = 1'b1; ticks(4); ov_any = 1'b0;
        pack_off = 1'b1; step();
        outs_is("R11 ov and disable", 1'b1, 1'b1, 1'b0);
        pack_off = 1'b0; step();
        outs_is("R11 ov remains after disable", 1'b1, 1'b0, 1'b0);
        ce_all = 1'b1; step(); ce_all = 1'b0; step();
    endtask

    task automatic t_uv();
        uv_any = 1'b1; ticks(2);
        outs_is("R3 before uv expiry", 1'b0, 1'b0, 1'b0);
        ticks(1);
        outs_is("R3 uv enters sleep", 1'b0, 1'b1, 1'b1);
        uv_any = 1'b0; ticks(2);
        outs_is("R5 stays asleep after uv clears", 1'b0, 1'b1, 1'b1);
        cd_lo = 1'b1; step(); cd_lo = 1'b0; step();
        outs_is("R5 wake on cd_lo", 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        step();
        t_reset();
        t_wake();
        t_ov();
        t_restart();
        t_zero();
        t_oc();
        t_disable();
        t_combo();
        t_uv();
        finish_run();
    end
endmodule